// File: doc/BRIEF.md
# Two-Digit Challenge Combination Lock

This block checks a five-digit key without ever asking for all of it at once. When the user presses the challenge button, the block picks two different key positions and asks for them in turn. The user sets each digit on the switches and confirms it with a load pulse. After the second digit, the block reports whether both digits were right.

The choice of positions comes from a counter that runs on every clock from 0 to 19. The button press freezes its value. That value selects one entry from a table of all ordered pairs of distinct positions. Since the press arrives at an unpredictable cycle, successive challenges usually ask for different pairs.

The requested position appears on an output while the block waits for each digit. A valid flag and a match flag present the verdict.

Top module: `pair_challenge_lock`

## Requirements
- R1: While reset is high and in the cycle after it is released, `req_pos`, `result_valid` and `match` are 0, and the block waits idle.
- R2: The selection counter resets to 0 and advances by one each clock, wrapping from 19 to 0. In a cycle with `chal` high, it holds its value instead, and that value is captured as the selection index.
- R3: Index k selects the k-th ordered pair (a,b), with a≠b and both in 1..5. The pairs are listed with a as the major key and b as the minor key: index 0 is (1,2), index 7 is (2,5), index 19 is (5,4).
- R4: A `chal` pulse in any state clears both stored digits and moves to a setup state for one cycle, with all outputs 0. The first-digit state follows.
- R5: In the first-digit state, `req_pos` shows position a. A `load` pulse stores `sw` as the first digit and moves to the second-digit state, where `req_pos` shows position b.
- R6: In the second-digit state, a `load` pulse stores `sw` as the second digit and moves to the result state, where `result_valid` is 1 and `req_pos` is 0.
- R7: In the result state, `match` is 1 only when the first digit equals the key digit at position a and the second digit equals the key digit at position b. The key holds the digits 4,2,7,5,7 at positions 1 to 5. Position p occupies bits [4p-1:4p-4] of the key parameter.
- R8: A `load` pulse in the idle, setup or result state is ignored: the state, `result_valid` and `match` stay unchanged.
- R9: When `chal` and `load` are high in the same cycle, `chal` wins and the digit is not stored.
- R10: `req_pos` is 0 outside the two digit states, and `match` is 0 whenever `result_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| chal | input | 1 | Challenge pulse: start a new two-digit challenge |
| load | input | 1 | Load pulse: take the switch value as the next digit |
| sw | input | DIGIT_W | Digit set on the switches |
| req_pos | output | POS_W | Requested key position (1..NUM_POS), 0 when no digit is requested |
| result_valid | output | 1 | Verdict is available |
| match | output | 1 | Both entered digits were correct |

## Verification
On every cycle, the embedded assertions check the following:
- the counter stays in range and steps correctly;
- any challenge leads to setup on the next cycle;
- the two requested positions are distinct and in range;
- loads move the machine one digit state forward;
- the result state holds its verdict until the next challenge.

Some behaviours only the directed scenarios can show. These are the pair chosen for a given counter value, the key digit that each position maps to, and match versus mismatch for specific entries. The same holds for restart in the middle of an entry and for a load that arrives together with a challenge.

// File: rtl/pcl_pkg.sv
package pcl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_SETUP  = 3'd1,
      ST_FIRST  = 3'd2,
      ST_SECOND = 3'd3,
      ST_RESULT = 3'd4
   } pcl_state_t;

   // Position of the k-th ordered pair of distinct positions out of n.
   // want_second selects the minor element of the pair.
   function automatic int pair_elem(input int k, input int n, input bit want_second);
      int cnt;
      int res;
      cnt = 0;
      res = 0;
      for (int a = 1; a <= n; a++) begin
         for (int b = 1; b <= n; b++) begin
            if (a != b) begin
               if (cnt == k) res = want_second ? b : a;
               cnt++;
            end
         end
      end
      return res;
   endfunction

endpackage

// File: rtl/pcl_index_ctr.sv
module pcl_index_ctr #(
   parameter int NPAIR = 20,
   parameter int IDX_W = 5
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             freeze,
   output logic [IDX_W-1:0] sel_o
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(NPAIR - 1);

   logic [IDX_W-1:0] cnt_q;

   initial begin
      if (NPAIR < 2) $error("NPAIR must be at least 2");
      if ((1 << IDX_W) < NPAIR) $error("IDX_W too narrow for NPAIR");
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
         sel_o <= '0;
      end else if (freeze) begin
         sel_o <= cnt_q;
      end else begin
         cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      end
   end

   AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
      cnt_q <= LAST);  // R2
   AST_IDX_STEP: assert property (@(posedge clk) disable iff (rst)
      (!freeze && cnt_q != LAST) |=> cnt_q == $past(cnt_q) + 1'b1);  // R2
   AST_IDX_FROZEN: assert property (@(posedge clk) disable iff (rst)
      freeze |=> (sel_o == $past(cnt_q) && $stable(cnt_q)));  // R2

endmodule

// File: rtl/pcl_pair_table.sv
module pcl_pair_table #(
   parameter int NUM_POS = 5,
   parameter int IDX_W   = 5,
   parameter int POS_W   = 3
) (
   input  logic [IDX_W-1:0] sel_i,
   output logic [POS_W-1:0] pos_a_o,
   output logic [POS_W-1:0] pos_b_o
);
   localparam int NPAIR = NUM_POS * (NUM_POS - 1);

   logic [POS_W-1:0] tbl_a [NPAIR];
   logic [POS_W-1:0] tbl_b [NPAIR];

   initial begin
      if ((1 << POS_W) <= NUM_POS) $error("POS_W too narrow for NUM_POS");
   end

   for (genvar g = 0; g < NPAIR; g++) begin : g_entry
      localparam int PA = pcl_pkg::pair_elem(g, NUM_POS, 1'b0);
      localparam int PB = pcl_pkg::pair_elem(g, NUM_POS, 1'b1);
      assign tbl_a[g] = POS_W'(PA);
      assign tbl_b[g] = POS_W'(PB);
   end

   always_comb begin
      pos_a_o = '0;
      pos_b_o = '0;
      for (int k = 0; k < NPAIR; k++) begin
         if (sel_i == IDX_W'(k)) begin
            pos_a_o = tbl_a[k];
            pos_b_o = tbl_b[k];
         end
      end
   end

endmodule

// File: rtl/pcl_key_pick.sv
module pcl_key_pick #(
   parameter int                       NUM_POS = 5,
   parameter int                       DIGIT_W = 4,
   parameter int                       POS_W   = 3,
   parameter logic [NUM_POS*DIGIT_W-1:0] KEY   = '0
) (
   input  logic [POS_W-1:0]   pos_i,
   output logic [DIGIT_W-1:0] digit_o
);
   always_comb begin
      digit_o = '0;
      for (int p = 1; p <= NUM_POS; p++) begin
         if (pos_i == POS_W'(p)) digit_o = KEY[(p-1)*DIGIT_W +: DIGIT_W];
      end
   end
endmodule

// File: rtl/pcl_ctrl.sv
module pcl_ctrl
   import pcl_pkg::*;
#(
   parameter int NUM_POS = 5,
   parameter int DIGIT_W = 4,
   parameter int POS_W   = 3
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               chal,
   input  logic               load,
   input  logic [DIGIT_W-1:0] sw,
   input  logic [POS_W-1:0]   pos_a,
   input  logic [POS_W-1:0]   pos_b,
   input  logic [DIGIT_W-1:0] key_a,
   input  logic [DIGIT_W-1:0] key_b,
   output logic [POS_W-1:0]   req_pos,
   output logic               result_valid,
   output logic               match
);
   pcl_state_t        state_q;
   logic [DIGIT_W-1:0] usr_q [2];
   logic [DIGIT_W-1:0] exp_q [2];

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_IDLE;
         for (int i = 0; i < 2; i++) begin
            usr_q[i] <= '0;
            exp_q[i] <= '0;
         end
      end else if (chal) begin
         state_q <= ST_SETUP;
         for (int i = 0; i < 2; i++) begin
            usr_q[i] <= '0;
            exp_q[i] <= '0;
         end
      end else begin
         case (state_q)
            ST_SETUP: begin
               exp_q[0] <= key_a;
               exp_q[1] <= key_b;
               state_q  <= ST_FIRST;
            end
            ST_FIRST: if (load) begin
               usr_q[0] <= sw;
               state_q  <= ST_SECOND;
            end
            ST_SECOND: if (load) begin
               usr_q[1] <= sw;
               state_q  <= ST_RESULT;
            end
            default: state_q <= state_q;
         endcase
      end
   end

   always_comb begin
      req_pos = '0;
      if (state_q == ST_FIRST)  req_pos = pos_a;
      if (state_q == ST_SECOND) req_pos = pos_b;
   end

   assign result_valid = (state_q == ST_RESULT);
   assign match = result_valid && (usr_q[0] == exp_q[0]) && (usr_q[1] == exp_q[1]);

   AST_CHAL_RESTART: assert property (@(posedge clk) disable iff (rst)
      chal |=> state_q == ST_SETUP);  // R4
   AST_PAIR_DISTINCT: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_FIRST) |-> (pos_a != pos_b && pos_a != '0 && pos_b != '0
                                  && pos_a <= POS_W'(NUM_POS) && pos_b <= POS_W'(NUM_POS)));  // R3
   AST_FIRST_ADV: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_FIRST && load && !chal) |=> state_q == ST_SECOND);  // R5
   AST_SECOND_ADV: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_SECOND && load && !chal) |=> result_valid);  // R6
   AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
      (result_valid && !chal) |=> (result_valid && $stable(match)));  // R8
   AST_IDLE_STAY: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_IDLE && !chal) |=> state_q == ST_IDLE);  // R8
   AST_MATCH_GATED: assert property (@(posedge clk) disable iff (rst)
      !result_valid |-> !match);  // R10

endmodule

// File: rtl/pair_challenge_lock.sv
module pair_challenge_lock #(
   parameter int                         NUM_POS = 5,
   parameter int                         DIGIT_W = 4,
   parameter int                         POS_W   = $clog2(NUM_POS + 1),
   parameter logic [NUM_POS*DIGIT_W-1:0] KEY     = 20'h75724
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               chal,
   input  logic               load,
   input  logic [DIGIT_W-1:0] sw,
   output logic [POS_W-1:0]   req_pos,
   output logic               result_valid,
   output logic               match
);
   localparam int NPAIR = NUM_POS * (NUM_POS - 1);
   localparam int IDX_W = $clog2(NPAIR);

   initial begin
      if (NUM_POS < 2) $error("NUM_POS must be at least 2");
      if (DIGIT_W < 1) $error("DIGIT_W must be positive");
   end

   logic [IDX_W-1:0]   sel;
   logic [POS_W-1:0]   pos_a, pos_b;
   logic [DIGIT_W-1:0] key_a, key_b;

   pcl_index_ctr #(.NPAIR(NPAIR), .IDX_W(IDX_W)) u_idx (
      .clk(clk), .rst(rst), .freeze(chal), .sel_o(sel));

   pcl_pair_table #(.NUM_POS(NUM_POS), .IDX_W(IDX_W), .POS_W(POS_W)) u_tbl (
      .sel_i(sel), .pos_a_o(pos_a), .pos_b_o(pos_b));

   pcl_key_pick #(.NUM_POS(NUM_POS), .DIGIT_W(DIGIT_W), .POS_W(POS_W), .KEY(KEY)) u_key_a (
      .pos_i(pos_a), .digit_o(key_a));

   pcl_key_pick #(.NUM_POS(NUM_POS), .DIGIT_W(DIGIT_W), .POS_W(POS_W), .KEY(KEY)) u_key_b (
      .pos_i(pos_b), .digit_o(key_b));

   pcl_ctrl #(.NUM_POS(NUM_POS), .DIGIT_W(DIGIT_W), .POS_W(POS_W)) u_ctrl (
      .clk(clk), .rst(rst), .chal(chal), .load(load), .sw(sw),
      .pos_a(pos_a), .pos_b(pos_b), .key_a(key_a), .key_b(key_b),
      .req_pos(req_pos), .result_valid(result_valid), .match(match));

endmodule

// File: tb/pair_challenge_lock_test.sv
module pair_challenge_lock_test;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       chal = 1'b0;
   logic       load = 1'b0;
   logic [3:0] sw = '0;
   logic [2:0] req_pos;
   logic       result_valid, match;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   int m_cnt = 0;
   int m_sel = 0;

   pair_challenge_lock uut (
      .clk(clk), .rst(rst), .chal(chal), .load(load), .sw(sw),
      .req_pos(req_pos), .result_valid(result_valid), .match(match));

   always #10 clk = ~clk;

   // Reference model of the selection counter (R2)
   always @(posedge clk) begin
      if (rst) m_cnt <= 0;
      else if (chal) m_sel <= m_cnt;
      else m_cnt <= (m_cnt == 19) ? 0 : m_cnt + 1;
   end

   function automatic int pa(int k);
      return k / 4 + 1;
   endfunction
   function automatic int pb(int k);
      int r = k % 4;
      return (r + 1 >= pa(k)) ? r + 2 : r + 1;
   endfunction
   function automatic int kd(int p);
      case (p)
         1: return 4;
         2: return 2;
         3: return 7;
         4: return 5;
         default: return 7;
      endcase
   endfunction

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic start_at(int idx);
      while (m_cnt != idx) @(negedge clk);
      chal = 1'b1;
      @(negedge clk);
      chal = 1'b0;
      chk("R4 setup req_pos", req_pos, 0);
      chk("R4 setup valid", result_valid, 0);
      @(negedge clk);
      chk("R3 first position", req_pos, pa(idx));
   endtask

   task automatic enter(int d);
      sw = 4'(d);
      load = 1'b1;
      @(negedge clk);
      load = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 req_pos", req_pos, 0);
      chk("R1 valid", result_valid, 0);
      chk("R1 match", match, 0);
   endtask

   task automatic t_idle_load();
      enter(4);
      chk("R8 idle load req_pos", req_pos, 0);
      chk("R8 idle load valid", result_valid, 0);
   endtask

   task automatic t_good(int idx);
      start_at(idx);
      enter(kd(pa(idx)));
      chk("R5 second position", req_pos, pb(idx));
      chk("R10 valid low mid entry", result_valid, 0);
      enter(kd(pb(idx)));
      chk("R6 valid", result_valid, 1);
      chk("R6 req_pos cleared", req_pos, 0);
      chk("R7 match on correct digits", match, 1);
   endtask

   task automatic t_bad_second(int idx);
      start_at(idx);
      enter(kd(pa(idx)));
      enter(kd(pb(idx)) ^ 1);
      chk("R6 valid", result_valid, 1);
      chk("R7 mismatch on wrong second", match, 0);
      enter(kd(pb(idx)));
      chk("R8 result load ignored valid", result_valid, 1);
      chk("R8 result load ignored match", match, 0);
   endtask

   task automatic t_bad_first(int idx);
      start_at(idx);
      enter(kd(pa(idx)) ^ 2);
      enter(kd(pb(idx)));
      chk("R7 mismatch on wrong first", match, 0);
      chk("R10 valid", result_valid, 1);
   endtask

   task automatic t_restart(int idx1, int idx2);
      start_at(idx1);
      enter(kd(pa(idx1)));
      start_at(idx2);
      chk("R10 valid after restart", result_valid, 0);
      enter(kd(pa(idx2)));
      enter(kd(pb(idx2)));
      chk("R4 restart match", match, 1);
   endtask

   task automatic t_chal_load(int idx);
      while (m_cnt != idx) @(negedge clk);
      chal = 1'b1;
      load = 1'b1;
      sw = 4'(kd(pa(idx)));
      @(negedge clk);
      chal = 1'b0;
      load = 1'b0;
      chk("R9 setup after both", req_pos, 0);
      @(negedge clk);
      chk("R9 still asks first", req_pos, pa(idx));
      enter(kd(pa(idx)));
      chk("R9 then second", req_pos, pb(idx));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst = 1'b0;
      @(negedge clk);
      t_reset();
      t_idle_load();
      t_good(0);      // R3 (1,2)
      t_good(19);     // R3 (5,4)
      t_good(4);      // R2 wrap-through
      t_bad_second(7);
      t_bad_first(13);
      t_restart(10, 2);
      t_chal_load(15);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule